// File: doc/BRIEF.md
# Successive-Approximation Conversion and Bus Controller

This block is the digital control side of a 12-bit successive-approximation converter. A decoded command on its chip-enable, active-low chip-select, read/convert and address inputs starts a conversion. It then puts the sample/hold into hold and enables the bit clock. It presents one trial word per clock to an external DAC and builds the result from a single comparator bit, from the most significant bit down. A short 8-bit conversion is available. Once started, a conversion runs to its end.

After the last trial the controller releases hold and stops the bit clock. It keeps `busy` high for a parameterised acquisition interval. Reads are refused while bits are being resolved and accepted at any other time, including the acquisition interval. A read returns the result either as one 12-bit word or as two bytes. The low byte is padded with four zero bits. The data bus is modelled as a value plus an output-enable.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `chip_en` is low or `cs_n` is high, no conversion starts and `bus_oe` is low, whatever the other control inputs are.
- R2: With `busy` low, a clock edge seeing `chip_en`=1, `cs_n`=0, `rd_conv_n`=0 starts a conversion, and `busy` is high after that edge. `addr0`=0 selects 12 trials and `addr0`=1 selects 8 trials.
- R3: After the starting edge, `hold` and `clk_en` are high for exactly 12 cycles (8 cycles for a short conversion), then low.
- R4: Bit trials run MSB first, one per cycle. `trial_word` is the bits kept so far plus the bit under test. A bit is kept when `cmp_hi`=1 (input not below the trial word). With an ideal comparator the result equals the input code. `trial_word` is zero while `hold` is low.
- R5: A short conversion leaves result bits [3:0] at zero.
- R6: Start commands that arrive while `busy` is high are ignored. Both the result and the length of the busy period are unaffected.
- R7: `bus_oe` stays low for every cycle in which `hold` is high, even when a read is decoded.
- R8: After `hold` falls, `busy` stays high for `ACQ_CYCLES` more cycles, so it is high for 12+`ACQ_CYCLES` (or 8+`ACQ_CYCLES`) cycles in total.
- R9: A read decoded during the acquisition interval is honoured and returns the finished result.
- R10: A read is `chip_en`=1, `cs_n`=0, `rd_conv_n`=1, and raises `bus_oe` outside conversion. With `wide`=1, `bus_data` is the full 12-bit result.
- R11: With `wide`=0 and `addr0`=0, `bus_data` is {4'b0, result[11:4]}. With `wide`=0 and `addr0`=1, it is {4'b0, result[3:0], 4'b0000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_conv_n | input | 1 | 1 = read, 0 = start conversion |
| wide | input | 1 | 1 = 12-bit parallel read, 0 = byte read |
| addr0 | input | 1 | Conversion length or byte select |
| cmp_hi | input | 1 | Comparator: input not below trial word |
| trial_word | output | 12 | Word driven to the DAC |
| hold | output | 1 | Sample/hold in hold mode |
| clk_en | output | 1 | Bit clock enable |
| busy | output | 1 | Status flag |
| bus_data | output | 12 | Read data |
| bus_oe | output | 1 | Read data valid/driven |

## Verification
The assertions check several rules on every cycle: the bus stays off while hold is high, and a read is driven only under the read decode. The pad nibble of a low-byte read is zero, and the trial word is quiet outside conversion. The busy flag rises only on a decoded start and is still high when hold falls. Only the bench scenarios can show the conversion arithmetic: for every 12-bit input code the result must match. The same scenarios confirm the exact busy and hold lengths, that starts issued mid-conversion are ignored, and the byte-read layout.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             cs_n,
  input  logic             rd_conv_n,
  input  logic             wide,
  input  logic             addr0,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial_word,
  output logic             hold,
  output logic             clk_en,
  output logic             busy,
  output logic [WIDTH-1:0] bus_data,
  output logic             bus_oe
);
  localparam int IW  = $clog2(WIDTH);
  localparam int AW  = $clog2(ACQ_CYCLES + 1);
  localparam int PAD = WIDTH - SHORT_BITS;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_ACQ} state_t;

  state_t           state;
  logic [WIDTH-1:0] sar;
  logic [IW-1:0]    idx, stop_idx;
  logic [AW-1:0]    acq_cnt;

  wire start_cmd = chip_en & ~cs_n & ~rd_conv_n;
  wire read_cmd  = chip_en & ~cs_n &  rd_conv_n;
  wire converting = (state == S_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sar      <= '0;
      idx      <= '0;
      stop_idx <= '0;
      acq_cnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_cmd) begin
          state    <= S_CONV;
          sar      <= '0;
          idx      <= IW'(WIDTH - 1);
          stop_idx <= addr0 ? IW'(PAD) : '0;
        end
        S_CONV: begin
          if (cmp_hi) sar[idx] <= 1'b1;
          if (idx == stop_idx) begin
            state   <= S_ACQ;
            acq_cnt <= AW'(ACQ_CYCLES - 1);
          end else begin
            idx <= idx - 1'b1;
          end
        end
        S_ACQ: if (acq_cnt == '0) state <= S_IDLE;
               else acq_cnt <= acq_cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign trial_word = converting ? (sar | (WIDTH'(1) << idx)) : '0;
  assign hold       = converting;
  assign clk_en     = converting;
  assign busy       = (state != S_IDLE);
  assign bus_oe     = read_cmd & ~converting;

  wire [WIDTH-1:0] hi_byte = {{PAD{1'b0}}, sar[WIDTH-1 -: SHORT_BITS]};
  wire [WIDTH-1:0] lo_byte = {{(WIDTH-PAD){1'b0}}, sar[PAD-1:0]} << PAD;

  assign bus_data = !bus_oe ? '0 : wide ? sar : (addr0 ? lo_byte : hi_byte);
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int WIDTH = 12,
  parameter int PAD   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_en,
  input logic             cs_n,
  input logic             rd_conv_n,
  input logic             wide,
  input logic             addr0,
  input logic [WIDTH-1:0] trial_word,
  input logic             hold,
  input logic             clk_en,
  input logic             busy,
  input logic [WIDTH-1:0] bus_data,
  input logic             bus_oe
);
  AST_BUS_OFF_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n) hold |-> !bus_oe); // R7
  AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> (chip_en && !cs_n && rd_conv_n)); // R1
  AST_NO_STRAY_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !(chip_en && !cs_n && !rd_conv_n)) |=> !busy); // R2
  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && chip_en && !cs_n && !rd_conv_n) |=> (busy && hold && clk_en)); // R3
  AST_ACQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $fell(hold) |-> busy); // R8
  AST_TRIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !hold |-> (trial_word == '0)); // R4
  AST_LOW_PAD: assert property (@(posedge clk) disable iff (!rst_n) (bus_oe && !wide && addr0) |-> (bus_data[PAD-1:0] == '0)); // R11
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH), .PAD(PAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cs_n(cs_n), .rd_conv_n(rd_conv_n),
  .wide(wide), .addr0(addr0), .trial_word(trial_word), .hold(hold), .clk_en(clk_en),
  .busy(busy), .bus_data(bus_data), .bus_oe(bus_oe)
);

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
  localparam int ACQ = 4;
  logic clk = 0, rst_n = 0;
  logic chip_en = 0, cs_n = 1, rd_conv_n = 1, wide = 0, addr0 = 0;
  logic [11:0] vin = 0;
  logic [11:0] trial_word, bus_data;
  logic hold, clk_en, busy, bus_oe, cmp_hi;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign cmp_hi = (vin >= trial_word);

  sar_conv_ctrl #(.WIDTH(12), .SHORT_BITS(8), .ACQ_CYCLES(ACQ)) dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cs_n(cs_n), .rd_conv_n(rd_conv_n),
    .wide(wide), .addr0(addr0), .cmp_hi(cmp_hi), .trial_word(trial_word), .hold(hold),
    .clk_en(clk_en), .busy(busy), .bus_data(bus_data), .bus_oe(bus_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    chip_en = 1; cs_n = 1; rd_conv_n = 1;
  endtask

  task automatic convert(input logic [11:0] v, input bit short_c);
    int n, nbits;
    logic [11:0] exp_r;
    nbits = short_c ? 8 : 12;
    exp_r = short_c ? (v & 12'hFF0) : v;
    vin = v;
    @(negedge clk);
    chip_en = 1; cs_n = 0; rd_conv_n = 0; addr0 = short_c;
    @(negedge clk);
    chk(busy == 1, "R2 busy after start", busy, 1);
    n = 0;
    while (busy && n < 40) begin
      n++;
      chk(hold == (n <= nbits) && clk_en == (n <= nbits), "R3 hold/clk_en window", hold, n <= nbits);
      if (n == 2) begin
        chip_en = 1; cs_n = 0; rd_conv_n = 1; wide = 1; #1;
        chk(bus_oe == 0, "R7 read blocked in conversion", bus_oe, 0);
      end else if (n == 4) begin
        chip_en = 1; cs_n = 0; rd_conv_n = 0; addr0 = ~short_c;
      end else if (n == nbits + 1) begin
        chip_en = 1; cs_n = 0; rd_conv_n = 1; wide = 1; #1;
        chk(bus_oe == 1 && bus_data == exp_r, "R9 read in acquisition", bus_data, exp_r);
      end else idle_bus();
      @(negedge clk);
    end
    chk(n == nbits + ACQ, "R8 R6 busy length", n, nbits + ACQ);
    chip_en = 1; cs_n = 0; rd_conv_n = 1; wide = 1; #1;
    chk(bus_oe && bus_data == exp_r, short_c ? "R5 short result" : "R4 R10 full result", bus_data, exp_r);
    wide = 0; addr0 = 0; #1;
    chk(bus_data == {4'b0, exp_r[11:4]}, "R11 high byte", bus_data, {4'b0, exp_r[11:4]});
    addr0 = 1; #1;
    chk(bus_data == {4'b0, exp_r[3:0], 4'b0}, "R11 low byte padded", bus_data, {4'b0, exp_r[3:0], 4'b0});
    idle_bus();
  endtask

  initial begin
    #1;
    chk(busy == 0 && hold == 0 && clk_en == 0 && bus_oe == 0, "R2 reset state", busy, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chip_en = 0; cs_n = 0; rd_conv_n = 0; #1;
    chk(bus_oe == 0, "R1 no read when disabled", bus_oe, 0);
    @(negedge clk);
    chk(busy == 0, "R1 no start with chip_en low", busy, 0);
    chip_en = 1; cs_n = 1; rd_conv_n = 0;
    @(negedge clk);
    chk(busy == 0, "R1 no start with cs_n high", busy, 0);
    rd_conv_n = 1; #1;
    chk(bus_oe == 0, "R1 no read with cs_n high", bus_oe, 0);
    for (int v = 0; v < 4096; v++) convert(12'(v), 0);
    for (int v = 0; v < 256; v++) convert(12'(v * 16 + (v % 16)), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule